// File: doc/BRIEF.md
# Low-Power Mode Wake-Up Controller

This controller sits beside a processor core and decides how deeply the chip sleeps when the core issues an idle request, and which events bring it back. A two-bit sleep-depth field, held in a small register inside the block, picks one of four depths. Each depth gates more clock domains than the one before: first the CPU clock, then the peripheral clock, then the PLL, and finally the oscillator. The field is latched when the core goes to sleep, so a write during sleep does not change the depth already in force.

Wake events are a generic unmasked CPU interrupt, a watchdog real-time interrupt, a non-maskable interrupt and a parameterised number of maskable external interrupt pins. Each pin has its own enable, and a global enable applies to all of them. All event inputs pass through two-flop synchronizers. Each depth accepts its own set of wake events. The shallowest depth accepts everything. The watchdog cannot wake the deepest depth. The external events can wake any depth. After a wake from the PLL or oscillator depth, the stopped source is enabled again first. The CPU clock stays gated for a programmable settle time, and then a one-cycle wake acknowledge is raised. The active-low reset is asynchronous and returns everything to the run state at once.

The state machine has four states. RUN: all clocks run. An idle request with no pending qualified wake moves to SLEEP; with a pending wake it stays in RUN. SLEEP: clocks are gated per the latched depth. A qualified wake moves to ACK for the two shallow depths, or to SETTLE for the PLL and oscillator depths. SETTLE: sources are on and the CPU clock is still gated. When the settle counter reaches zero it moves to ACK. ACK: all clocks run and the acknowledge is high for one cycle, then the machine returns to RUN.

Top module: `lpm_wake_ctrl`

## Requirements
- R1: The depth field is written through `mode_we`/`mode_wdata` and read on `mode_q`. The encoding is 00 = idle 1, 01 = idle 2, 10 = PLL off, 11 = oscillator off. Reset clears the field to 00.
- R2: While asleep, the enables {cpu_clk_en, per_clk_en, pll_en, osc_en} are 0111 for idle 1, 0011 for idle 2, 0001 for PLL off and 0000 for oscillator off. A stopped oscillator always implies a stopped PLL, and a stopped PLL implies gated CPU and peripheral clocks.
- R3: In idle 1, any of these wakes the core: the CPU interrupt, the watchdog interrupt, the non-maskable interrupt, or a qualified external pin.
- R4: The watchdog interrupt wakes idle 1, idle 2 and PLL off, and has no effect in oscillator off.
- R5: The non-maskable interrupt and a qualified external pin wake every depth, including oscillator off.
- R6: An external pin qualifies only when its own enable bit and `gie` are both 1.
- R7: For idle 1 and idle 2, `wake_ack` goes high on the third rising edge after a wake input is applied: two synchronizer stages plus one state step.
- R8: A wake from PLL off brings `wake_ack` on rising edge 3 + PLL_SETTLE. The CPU clock stays gated until that edge and rises only together with `wake_ack`.
- R9: A wake from oscillator off brings `wake_ack` on rising edge 3 + OSC_SETTLE. During the settle time the enables are 0011.
- R10: `wake_ack` lasts exactly one cycle, and all four enables are 1 in that cycle and in the cycle after.
- R11: Asserting `rst_n` low sets all four enables to 1 without waiting for a clock edge, and the block restarts in RUN.
- R12: An idle request while a qualified wake for the current depth is already pending causes no entry: all enables stay 1 and no `wake_ack` is given.
- R13: The CPU interrupt alone has no effect in idle 2, PLL off and oscillator off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Write strobe for the depth field |
| mode_wdata | input | 2 | New depth field value |
| mode_q | output | 2 | Current depth field |
| idle_req | input | 1 | One-cycle idle request from the core |
| cpu_irq | input | 1 | Generic unmasked CPU interrupt (asynchronous) |
| wdt_irq | input | 1 | Watchdog real-time interrupt (asynchronous) |
| nmi | input | 1 | Non-maskable external interrupt (asynchronous) |
| xint | input | NX | Maskable external interrupt pins (asynchronous) |
| xint_en | input | NX | Individual enables for the pins |
| gie | input | 1 | Global interrupt enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| pll_en | output | 1 | PLL enable |
| osc_en | output | 1 | Oscillator enable |
| wake_ack | output | 1 | One-cycle wake acknowledge |

## Verification
The hardest cases to reach are the ones where an event must have no effect: a watchdog event in oscillator off, a CPU interrupt in the idle 2 and deeper depths, and a pin that is enabled while the global enable is off. In each case the machine must stay asleep with the right enables, and then still wake correctly on a later event. The stimulus enters each depth, holds random combinations of events and enables for ten cycles, and checks the clock enables against a bench-computed wake matrix. When the matrix predicts no wake, it then fires the non-maskable interrupt and measures the wake latency. Directed cases cover an idle request over a pending event and a reset in the middle of sleep.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE1  = 2'b00,
        MODE_IDLE2  = 2'b01,
        MODE_PLLOFF = 2'b10,
        MODE_OSCOFF = 2'b11
    } lpm_mode_e;

    typedef enum logic [1:0] {
        ST_RUN    = 2'b00,
        ST_SLEEP  = 2'b01,
        ST_SETTLE = 2'b10,
        ST_ACK    = 2'b11
    } lpm_state_e;

endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual import lpm_pkg::*; #(
    parameter int NX = 3
) (
    input  lpm_mode_e       mode,
    input  logic            cpu_irq_s,
    input  logic            wdt_irq_s,
    input  logic            nmi_s,
    input  logic [NX-1:0]   xint_s,
    input  logic [NX-1:0]   xint_en,
    input  logic            gie,
    output logic            hit
);
    logic ext_hit;

    assign ext_hit = nmi_s | (|(xint_s & xint_en & {NX{gie}}));

    always_comb begin
        unique case (mode)
            MODE_IDLE1:  hit = cpu_irq_s | wdt_irq_s | ext_hit;
            MODE_IDLE2:  hit = wdt_irq_s | ext_hit;
            MODE_PLLOFF: hit = wdt_irq_s | ext_hit;
            MODE_OSCOFF: hit = ext_hit;
        endcase
    end
endmodule

// File: rtl/lpm_settle_cnt.sv
module lpm_settle_cnt #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (load)          cnt <= load_val;
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/lpm_wake_ctrl.sv
module lpm_wake_ctrl import lpm_pkg::*; #(
    parameter int NX          = 3,
    parameter int SYNC_STAGES = 2,
    parameter int PLL_SETTLE  = 16,
    parameter int OSC_SETTLE  = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_we,
    input  logic [1:0]    mode_wdata,
    output logic [1:0]    mode_q,
    input  logic          idle_req,
    input  logic          cpu_irq,
    input  logic          wdt_irq,
    input  logic          nmi,
    input  logic [NX-1:0] xint,
    input  logic [NX-1:0] xint_en,
    input  logic          gie,
    output logic          cpu_clk_en,
    output logic          per_clk_en,
    output logic          pll_en,
    output logic          osc_en,
    output logic          wake_ack
);
    localparam int SETTLE_MAX = (PLL_SETTLE > OSC_SETTLE) ? PLL_SETTLE : OSC_SETTLE;
    localparam int CNT_W      = $clog2(SETTLE_MAX + 1);
    localparam int EV_W       = NX + 3;
    localparam logic [CNT_W-1:0] PLL_LOAD = CNT_W'(PLL_SETTLE - 1);
    localparam logic [CNT_W-1:0] OSC_LOAD = CNT_W'(OSC_SETTLE - 1);

    lpm_state_e       state, state_nxt;
    lpm_mode_e        depth_q, sleep_depth, qual_depth;
    logic [EV_W-1:0]  ev_s;
    logic             wake_hit, cnt_load, cnt_done;
    logic [CNT_W-1:0] cnt_val;

    // Depth field register (R1)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       depth_q <= MODE_IDLE1;
        else if (mode_we) depth_q <= lpm_mode_e'(mode_wdata);
    end
    assign mode_q = depth_q;

    lpm_sync #(.W(EV_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cpu_irq, wdt_irq, nmi, xint}),
        .q     (ev_s)
    );

    assign qual_depth = (state == ST_RUN) ? depth_q : sleep_depth;

    lpm_wake_qual #(.NX(NX)) u_qual (
        .mode      (qual_depth),
        .cpu_irq_s (ev_s[NX+2]),
        .wdt_irq_s (ev_s[NX+1]),
        .nmi_s     (ev_s[NX]),
        .xint_s    (ev_s[NX-1:0]),
        .xint_en   (xint_en),
        .gie       (gie),
        .hit       (wake_hit)
    );

    lpm_settle_cnt #(.W(CNT_W)) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .done     (cnt_done)
    );

    // Next-state logic
    always_comb begin
        state_nxt = state;
        cnt_load  = 1'b0;
        cnt_val   = '0;
        unique case (state)
            ST_RUN: begin
                if (idle_req && !wake_hit) state_nxt = ST_SLEEP;   // R12
            end
            ST_SLEEP: begin
                if (wake_hit) begin
                    if (sleep_depth == MODE_PLLOFF) begin
                        state_nxt = ST_SETTLE;
                        cnt_load  = 1'b1;
                        cnt_val   = PLL_LOAD;
                    end else if (sleep_depth == MODE_OSCOFF) begin
                        state_nxt = ST_SETTLE;
                        cnt_load  = 1'b1;
                        cnt_val   = OSC_LOAD;
                    end else begin
                        state_nxt = ST_ACK;
                    end
                end
            end
            ST_SETTLE: begin
                if (cnt_done) state_nxt = ST_ACK;
            end
            ST_ACK: state_nxt = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= ST_RUN;
            sleep_depth <= MODE_IDLE1;
        end else begin
            state <= state_nxt;
            if (state == ST_RUN && idle_req && !wake_hit) sleep_depth <= depth_q;
        end
    end

    // Outputs (R2, R9, R10)
    always_comb begin
        cpu_clk_en = 1'b1;
        per_clk_en = 1'b1;
        pll_en     = 1'b1;
        osc_en     = 1'b1;
        wake_ack   = 1'b0;
        unique case (state)
            ST_RUN: ;
            ST_SLEEP: begin
                cpu_clk_en = 1'b0;
                per_clk_en = (sleep_depth == MODE_IDLE1);
                pll_en     = (sleep_depth == MODE_IDLE1) || (sleep_depth == MODE_IDLE2);
                osc_en     = (sleep_depth != MODE_OSCOFF);
            end
            ST_SETTLE: begin
                cpu_clk_en = 1'b0;
                per_clk_en = 1'b0;
            end
            ST_ACK: wake_ack = 1'b1;
        endcase
    end
endmodule

// File: rtl/lpm_wake_ctrl_chk.sv
module lpm_wake_ctrl_chk import lpm_pkg::*; (
    input logic       clk,
    input logic       rst_n,
    input lpm_state_e st,
    input logic       idle_req,
    input logic       wake_hit,
    input logic       cpu_clk_en,
    input logic       per_clk_en,
    input logic       pll_en,
    input logic       osc_en,
    input logic       wake_ack
);
    p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_ack |=> !wake_ack);

    p_ack_clocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_ack |-> (cpu_clk_en && per_clk_en && pll_en && osc_en));

    p_osc_chain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (!pll_en && !per_clk_en && !cpu_clk_en));

    p_pll_chain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_en |-> (!per_clk_en && !cpu_clk_en));

    p_cpu_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_clk_en) |-> wake_ack);

    p_no_sleep_pending_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && idle_req && wake_hit) |=> (st == ST_RUN && cpu_clk_en));

    p_settle_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SETTLE) |=> (st == ST_SETTLE || st == ST_ACK));
endmodule

bind lpm_wake_ctrl lpm_wake_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (state),
    .idle_req   (idle_req),
    .wake_hit   (wake_hit),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .pll_en     (pll_en),
    .osc_en     (osc_en),
    .wake_ack   (wake_ack)
);

// File: tb/lpm_wake_ctrl_test.sv
`timescale 1ns/1ps
module lpm_wake_ctrl_test;
    localparam int NX = 3;
    localparam int PLL_S = 16;
    localparam int OSC_S = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_we = 1'b0;
    logic [1:0] mode_wdata = 2'b00;
    logic [1:0] mode_q;
    logic idle_req = 1'b0, cpu_irq = 1'b0, wdt_irq = 1'b0, nmi = 1'b0, gie = 1'b0;
    logic [NX-1:0] xint = '0, xint_en = '0;
    logic cpu_clk_en, per_clk_en, pll_en, osc_en, wake_ack;

    int n_tests = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    lpm_wake_ctrl #(.NX(NX), .PLL_SETTLE(PLL_S), .OSC_SETTLE(OSC_S)) uut (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .mode_q(mode_q), .idle_req(idle_req), .cpu_irq(cpu_irq), .wdt_irq(wdt_irq),
        .nmi(nmi), .xint(xint), .xint_en(xint_en), .gie(gie),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .pll_en(pll_en),
        .osc_en(osc_en), .wake_ack(wake_ack)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic bit exp_wake(input int m, input bit c, input bit w, input bit n,
                                    input logic [NX-1:0] x, input logic [NX-1:0] e, input bit g);
        bit ext;
        ext = n | (|(x & e & {NX{g}}));
        case (m)
            0:       return c | w | ext;
            1, 2:    return w | ext;
            default: return ext;
        endcase
    endfunction

    function automatic int exp_lat(input int m);
        case (m)
            2:       return 3 + PLL_S;
            3:       return 3 + OSC_S;
            default: return 3;
        endcase
    endfunction

    function automatic logic [3:0] exp_en(input int m);
        case (m)
            0:       return 4'b0111;
            1:       return 4'b0011;
            2:       return 4'b0001;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic [3:0] en_now();
        return {cpu_clk_en, per_clk_en, pll_en, osc_en};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_mode(input int m);
        @(negedge clk);
        mode_we = 1'b1;
        mode_wdata = 2'(m);
        @(negedge clk);
        mode_we = 1'b0;
        check(mode_q == 2'(m), "R1 mode write", mode_q, m);
    endtask

    task automatic enter_sleep(input int m);
        write_mode(m);
        idle_req = 1'b1;
        @(negedge clk);
        idle_req = 1'b0;
        check(en_now() == exp_en(m), "R2 sleep enables", en_now(), exp_en(m));
    endtask

    task automatic clear_src();
        @(negedge clk);
        cpu_irq = 0; wdt_irq = 0; nmi = 0; xint = '0; xint_en = '0; gie = 0;
        repeat (3) @(negedge clk);
    endtask

    // Inputs were applied at the current negedge; count edges to wake_ack.
    task automatic wait_ack(input int m, input string req);
        int cyc;
        logic [3:0] en5;
        cyc = -1;
        en5 = 4'b1111;
        for (int i = 1; i <= 100; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (i == 5) en5 = en_now();
            if (wake_ack) begin
                cyc = i;
                break;
            end
        end
        check(cyc == exp_lat(m), req, cyc, exp_lat(m));
        if (m >= 2) check(en5 == 4'b0011, "R9 settle enables", en5, 3);
        check(en_now() == 4'b1111, "R10 clocks in ack", en_now(), 15);
        @(negedge clk);
        check(!wake_ack && en_now() == 4'b1111, "R10 ack one cycle", wake_ack, 0);
    endtask

    task automatic hold_asleep(input int m, input string req);
        bit ok;
        ok = 1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (wake_ack || en_now() != exp_en(m)) ok = 0;
        end
        check(ok, req, en_now(), exp_en(m));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        #1;
        check(en_now() == 4'b1111 && mode_q == 2'b00, "R11 reset state", en_now(), 15);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: every encoding
        for (int m = 0; m < 4; m++) write_mode(m);

        // R3: CPU interrupt wakes idle 1
        enter_sleep(0);
        cpu_irq = 1;
        wait_ack(0, "R7 idle1 cpu_irq latency (R3)");
        clear_src();

        // R13 + R4: CPU irq ignored in idle 2, watchdog wakes it
        enter_sleep(1);
        cpu_irq = 1;
        hold_asleep(1, "R13 cpu_irq ignored idle2");
        wdt_irq = 1;
        wait_ack(1, "R4 idle2 wdt latency");
        clear_src();

        // R8: PLL off by watchdog
        enter_sleep(2);
        wdt_irq = 1;
        wait_ack(2, "R8 pll settle latency");
        clear_src();

        // R4: watchdog ignored in oscillator off, R5: enabled pin wakes it
        enter_sleep(3);
        wdt_irq = 1;
        hold_asleep(3, "R4 wdt ignored oscoff");
        gie = 1; xint_en = 3'b010; xint = 3'b010;
        wait_ack(3, "R5 R9 oscoff xint latency");
        clear_src();

        // R6: pin enabled but global enable off
        enter_sleep(0);
        xint_en = 3'b111; xint = 3'b111; gie = 0;
        hold_asleep(0, "R6 gie off no wake");
        gie = 1; xint_en = 3'b000;
        hold_asleep(0, "R6 pin enable off no wake");
        nmi = 1;
        wait_ack(0, "R5 nmi idle1");
        clear_src();

        // R12: idle request with pending event
        write_mode(1);
        nmi = 1;
        repeat (3) @(negedge clk);
        idle_req = 1;
        @(negedge clk);
        idle_req = 0;
        check(en_now() == 4'b1111 && !wake_ack, "R12 no entry pending", en_now(), 15);
        repeat (3) @(negedge clk);
        check(en_now() == 4'b1111 && !wake_ack, "R12 still running", en_now(), 15);
        clear_src();

        // R11: async reset during oscillator off
        enter_sleep(3);
        #1 rst_n = 1'b0;
        #0.5;
        check(en_now() == 4'b1111, "R11 async clocks on", en_now(), 15);
        check(mode_q == 2'b00, "R11 mode cleared", mode_q, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Random sweep over the wake matrix
        for (int it = 0; it < 40; it++) begin
            int m;
            bit c, w, n, g, ew;
            logic [NX-1:0] x, e;
            m = int'($urandom % 4);
            c = ($urandom % 3) == 0;
            w = ($urandom % 3) == 0;
            n = ($urandom % 6) == 0;
            g = ($urandom % 2) == 0;
            x = NX'($urandom);
            e = NX'($urandom);
            ew = exp_wake(m, c, w, n, x, e, g);
            enter_sleep(m);
            cpu_irq = c; wdt_irq = w; nmi = n; xint = x; xint_en = e; gie = g;
            if (ew) begin
                wait_ack(m, "R3 R4 R5 matrix wake");
            end else begin
                hold_asleep(m, "R4 R6 R13 matrix no wake");
                nmi = 1;
                wait_ack(m, "R5 nmi after hold");
            end
            clear_src();
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule